// File: doc/BRIEF.md
# UART Sleep Mode Controller

This block decides when a single-channel UART core may stop its clocks and when it must start them again. Sleep is armed by two enable bits held in other registers. While sleep is armed and the UART has nothing to do, the controller raises a sleep indication and drops the clock-gate enable. That enable feeds the baud generator and the serial engines.

Several events wake the block:

- a start-bit strobe from the receiver front end;
- a host write to the transmit holding register;
- any change of level on the serial input or on the four modem inputs.

After waking, the controller returns to sleep by itself once the traffic has drained. That means the transmitter is empty, no received data is waiting, and no interrupt is pending. The drained condition must be seen at two clock edges in a row before sleep is entered. Clearing either enable bit keeps the block awake.

The pin inputs are asynchronous and pass through a synchronizer chain before change detection. The strobes and status inputs are synchronous to `clk`. The reset is asynchronous on assertion and released through a two-flop synchronizer.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: While reset is held and on the first clock edges after its release, `sleep_o` is 0 and `clk_en_o` is 1. At all times `clk_en_o` is the inverse of `sleep_o`.
- R2: If `feat_en` or `sleep_en` is 0 at a rising edge, `sleep_o` is 0 after that edge.
- R3: With both enables at 1 and no wake event, `sleep_o` rises at the second of two consecutive rising edges at which the idle condition is sampled true. The idle condition is `tx_empty`=1, `rx_avail`=0 and `irq_pending`=0.
- R4: `sleep_o` never rises at an edge at which `irq_pending` is 1, nor at the edge that follows.
- R5: `sleep_o` does not rise while `tx_empty` is 0 or `rx_avail` is 1, nor at the first edge after they return to idle.
- R6: A `rx_start` pulse sampled at an edge clears `sleep_o` after that edge.
- R7: A `thr_write` pulse sampled at an edge clears `sleep_o` after that edge.
- R8: A level change on any bit of `pins_i` wakes the block. The bits are {dcd, dsr, cts, ri, rx} with rx at bit 0. The change is set up before edge E1, and `sleep_o` clears after E3. The pin passes two synchronizer flops before it is compared with its held copy.
- R9: After a wake event with the UART otherwise idle, `sleep_o` returns to 1 on the second edge after the edge that cleared it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | Enhanced-feature enable bit |
| sleep_en | input | 1 | Sleep enable bit from the interrupt-enable register |
| rx_start | input | 1 | Start-bit detected strobe, synchronous |
| thr_write | input | 1 | Host write strobe to the transmit holding register |
| pins_i | input | 5 | Asynchronous pins {dcd, dsr, cts, ri, rx} |
| tx_empty | input | 1 | Transmit FIFO and shift register both empty |
| rx_avail | input | 1 | Receive data waiting to be read |
| irq_pending | input | 1 | At least one interrupt pending |
| sleep_o | output | 1 | Sleep indication |
| clk_en_o | output | 1 | Clock-gate enable for the baud and serial clocks |

## Verification
The assertions assume that `rx_start`, `thr_write` and the status inputs are synchronous to `clk` and settle before each rising edge. They also assume that `pins_i` holds its level long enough to cross the synchronizer. The bench changes every input only on falling edges. It holds `pins_i` steady through reset, so the synchronizer resets to the same level the pins carry and raises no spurious change. Strobes are always single-cycle pulses, and every pin toggle is held for several cycles before the next one.

// File: rtl/usc_pkg.sv
package usc_pkg;
  parameter int unsigned PIN_W     = 5;
  parameter int unsigned SYNC_DEPTH = 2;
  parameter int unsigned RST_DEPTH  = 2;
  typedef logic [PIN_W-1:0] pin_vec_t;
endpackage

// File: rtl/usc_pin_watch.sv
module usc_pin_watch #(
  parameter int unsigned W     = 5,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic         changed_o
);
  logic [W-1:0] sync_q [DEPTH];
  logic [W-1:0] held_q;

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= '0;
          else        sync_q[s] <= pins_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= '0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= sync_q[DEPTH-1];
  end

  assign changed_o = |(sync_q[DEPTH-1] ^ held_q);

  // R8
  held_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    changed_o |=> !$stable(held_q));
endmodule

// File: rtl/usc_idle_qual.sv
module usc_idle_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_empty,
  input  logic rx_avail,
  input  logic irq_pending,
  input  logic wake,
  output logic drained_o
);
  logic idle_now;
  logic idle_q;
  logic idle_d;

  always_comb begin
    idle_now = tx_empty && !rx_avail && !irq_pending && !wake;
    idle_d   = idle_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= 1'b0;
    else        idle_q <= idle_d;
  end

  assign drained_o = idle_now && idle_q;

  // R5
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty || rx_avail) |-> !drained_o);
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
  import usc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             feat_en,
  input  logic             sleep_en,
  input  logic             rx_start,
  input  logic             thr_write,
  input  logic [PIN_W-1:0] pins_i,
  input  logic             tx_empty,
  input  logic             rx_avail,
  input  logic             irq_pending,
  output logic             sleep_o,
  output logic             clk_en_o
);
  logic [RST_DEPTH-1:0] rst_sync_q;
  logic                 rst_int_n;
  logic                 pin_change;
  logic                 wake;
  logic                 drained;
  logic                 armed;
  logic                 asleep_q;
  logic                 asleep_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_DEPTH-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_DEPTH-1];

  usc_pin_watch #(.W(PIN_W), .DEPTH(SYNC_DEPTH)) u_pins (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pins_i    (pins_i),
    .changed_o (pin_change)
  );

  assign wake  = rx_start || thr_write || pin_change;
  assign armed = feat_en && sleep_en;

  usc_idle_qual u_idle (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tx_empty    (tx_empty),
    .rx_avail    (rx_avail),
    .irq_pending (irq_pending),
    .wake        (wake),
    .drained_o   (drained)
  );

  always_comb begin
    asleep_d = asleep_q;
    if (!armed || wake)   asleep_d = 1'b0;
    else if (drained)     asleep_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) asleep_q <= 1'b0;
    else            asleep_q <= asleep_d;
  end

  assign sleep_o  = asleep_q;
  assign clk_en_o = !asleep_q;

  // R2
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(feat_en && sleep_en) |=> !sleep_o);
  // R4
  irq_block_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!sleep_o && irq_pending) |=> !sleep_o);
  // R6
  start_wake_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_start |=> !sleep_o);
  // R7
  write_wake_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    thr_write |=> !sleep_o);
  // R3
  entry_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sleep_o) |-> $past(tx_empty && !rx_avail && !irq_pending));
endmodule

// File: tb/uart_sleep_ctrl_tb.sv
module uart_sleep_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       feat_en, sleep_en, rx_start, thr_write;
  logic [4:0] pins_i;
  logic       tx_empty, rx_avail, irq_pending;
  logic       sleep_o, clk_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    bit    chk;
    logic  exp;
    string req;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  uart_sleep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .sleep_en(sleep_en),
    .rx_start(rx_start), .thr_write(thr_write), .pins_i(pins_i),
    .tx_empty(tx_empty), .rx_avail(rx_avail), .irq_pending(irq_pending),
    .sleep_o(sleep_o), .clk_en_o(clk_en_o)
  );

  // monitor: pops one item per edge, samples 5 ns after it
  always @(posedge clk) begin
    item_t it;
    #5;
    if (sb_q.size() != 0) begin
      it = sb_q.pop_front();
      if (it.chk) begin
        checks++;
        if (sleep_o !== it.exp || clk_en_o !== !it.exp) begin
          fails++;
          $display("FAIL %s: sleep_o=%b clk_en_o=%b expected sleep_o=%b clk_en_o=%b",
                   it.req, sleep_o, clk_en_o, it.exp, !it.exp);
        end
      end
    end
  end

  // driver: inputs already set; queue the expectation for the coming edge
  task automatic step(input bit chk, input logic exp, input string req);
    item_t it;
    it.chk = chk; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic pulse_wake(input bit is_write, input string req);
    if (is_write) thr_write = 1'b1; else rx_start = 1'b1;
    step(1, 1'b0, req);
    thr_write = 1'b0; rx_start = 1'b0;
    step(1, 1'b0, "R9");
    step(1, 1'b1, "R9");
  endtask

  initial begin
    rst_n = 1'b0; feat_en = 0; sleep_en = 0; rx_start = 0; thr_write = 0;
    pins_i = '0; tx_empty = 1; rx_avail = 0; irq_pending = 0;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (sleep_o !== 1'b0 || clk_en_o !== 1'b1) begin
      fails++;
      $display("FAIL R1: sleep_o=%b clk_en_o=%b expected 0/1 in reset", sleep_o, clk_en_o);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1, 1'b0, "R1");
    // R2: only one enable set
    feat_en = 1;
    for (int i = 0; i < 3; i++) step(1, 1'b0, "R2");
    feat_en = 0; sleep_en = 1;
    for (int i = 0; i < 3; i++) step(1, 1'b0, "R2");
    // R3: both enables, idle already held
    feat_en = 1;
    step(1, 1'b1, "R3");
    step(1, 1'b1, "R3");
    sleep_en = 0;
    step(1, 1'b0, "R2");
    sleep_en = 1;
    step(1, 1'b1, "R3");
    // R6 / R7 / R9
    pulse_wake(0, "R6");
    pulse_wake(1, "R7");
    // R8: each pin toggled in turn
    for (int b = 0; b < 5; b++) begin
      pins_i[b] = ~pins_i[b];
      step(1, 1'b1, "R8");
      step(1, 1'b1, "R8");
      step(1, 1'b0, "R8");
      step(1, 1'b0, "R9");
      step(1, 1'b1, "R9");
    end
    // R4: interrupt pending holds the block awake
    irq_pending = 1;
    thr_write = 1;
    step(1, 1'b0, "R7");
    thr_write = 0;
    for (int i = 0; i < 4; i++) step(1, 1'b0, "R4");
    irq_pending = 0;
    step(1, 1'b0, "R4");
    step(1, 1'b1, "R3");
    // R5: transmitter busy
    thr_write = 1; tx_empty = 0;
    step(1, 1'b0, "R7");
    thr_write = 0;
    for (int i = 0; i < 3; i++) step(1, 1'b0, "R5");
    tx_empty = 1;
    step(1, 1'b0, "R5");
    step(1, 1'b1, "R5");
    // R5: receive data waiting
    rx_start = 1; rx_avail = 1;
    step(1, 1'b0, "R6");
    rx_start = 0;
    for (int i = 0; i < 3; i++) step(1, 1'b0, "R5");
    rx_avail = 0;
    step(1, 1'b0, "R5");
    step(1, 1'b1, "R5");
    step(0, 1'b0, "");
    step(0, 1'b0, "");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule